// File: doc/BRIEF.md
# Single-Bus Accumulator Datapath

This block is the register-transfer datapath of a small accumulator machine. Every transfer goes over one shared internal bus. An external sequencer drives it with a 15-bit control word each cycle. Within that cycle, at most one source places a word on the bus and any set of destination registers captures it at the clock edge. The bus sources are the memory read data, the program counter, the accumulator, the instruction register, the return-address register and the ALU result buffer.

The memory address register and the ALU argument register capture from the bus but never drive it. A four-function ALU combines the argument register with the bus. Its result is captured by a buffer register on every clock, so an arithmetic result has to be moved out in the cycle right after it is produced.

The block presents the following outputs:
- the memory address, write data, write strobe and request;
- the accumulator-zero flag and the opcode field;
- an interrupt-acknowledge flip-flop, set by writes to the return-address register and cleared by reads of it.

Whenever more than one source is enabled in the same cycle, the block raises a conflict flag and forces the bus to zero.

Top module: `bus_accum_datapath`

## Requirements
- R1: The control word is decoded with bit 14 = memory write strobe, 13 = memory read onto bus, 12 = load address register, 11 = load program counter, 10 = program counter onto bus, 9 = load accumulator, 8 = accumulator onto bus, 7 = load instruction register, 6 = instruction register onto bus, 5 = load return register, 4 = return register onto bus, 3 = load ALU argument, 2 and 1 = ALU select high and low, 0 = result buffer onto bus.
- R2: When exactly one read strobe is active, the bus carries that source's word. With no read strobe active, the bus is zero.
- R3: `bus_conflict` is high exactly when two or more read strobes are active. During such a cycle the bus is zero, so any register loaded in that cycle receives zero.
- R4: The program counter, accumulator, instruction, return, address and argument registers load the bus value at the clock edge when their load bit is set. Otherwise they hold their value.
- R5: ALU select 11 gives bus+1, 10 gives argument+bus, 01 gives argument−bus, and 00 gives zero. All arithmetic wraps modulo 2^16.
- R6: The result buffer captures the ALU output on every clock edge, with no enable.
- R7: `mem_wdata` equals the bus while the write strobe is set and is zero otherwise. `mem_wr` follows the write strobe. `mem_req` is the OR of the write strobe and the memory read strobe.
- R8: `iack` behaves as a JK flip-flop with J = return-register load and K = return-register read. Both set toggles it; neither set holds it.
- R9: `acc_zero` is high when the accumulator is zero. `opcode` is instruction-register bits 15:13. `mem_addr` is the low 13 bits of the address register.
- R10: A synchronous active-high reset clears every register and `iack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 15 | Control word from the sequencer |
| mem_rdata | input | 16 | Memory read data |
| mem_addr | output | 13 | Memory address from the address register |
| mem_wdata | output | 16 | Memory write data |
| mem_wr | output | 1 | Memory write strobe |
| mem_req | output | 1 | Memory request |
| acc_zero | output | 1 | Accumulator equals zero |
| opcode | output | 3 | Opcode field of the instruction register |
| iack | output | 1 | Interrupt acknowledge flip-flop |
| bus_conflict | output | 1 | Two or more bus sources enabled |

## Verification
The hardest state to observe from the ports is the contents of the internal registers. The stimulus exposes them by pairing a register's bus-read strobe with the memory write strobe, which copies the bus onto `mem_wdata`.

The ALU result buffer is overwritten every clock. Each ALU case is therefore a three-cycle sequence: load the argument, apply the operand with a select code, then read the buffer in the next cycle.

The conflict detector is swept over all 64 combinations of the six read strobes, with the registers preloaded with nonzero values. A conflicting cycle that also loads the accumulator checks that the zero reaches the registers.

// File: rtl/acc_dp_pkg.sv
package acc_dp_pkg;

    localparam int WORD_W = 16;
    localparam int OPC_W  = 3;
    localparam int ADDR_W = WORD_W - OPC_W;
    localparam int CTL_W  = 15;
    localparam int SRC_N  = 6;

    // control word, first member lands in the most significant bit
    typedef struct packed {
        logic mem_wr;
        logic mem_rd;
        logic mar_ld;
        logic pc_ld;
        logic pc_oe;
        logic acc_ld;
        logic acc_oe;
        logic ir_ld;
        logic ir_oe;
        logic rtn_ld;
        logic rtn_oe;
        logic arg_ld;
        logic fsel_hi;
        logic fsel_lo;
        logic buf_oe;
    } ctl_t;

    typedef enum logic [1:0] {
        ALU_ZERO = 2'b00,
        ALU_SUB  = 2'b01,
        ALU_ADD  = 2'b10,
        ALU_INC  = 2'b11
    } alu_op_e;

    // bus source slots
    typedef enum int {
        SRC_MEM = 0,
        SRC_PC  = 1,
        SRC_ACC = 2,
        SRC_IR  = 3,
        SRC_RTN = 4,
        SRC_BUF = 5
    } src_e;

    function automatic logic [SRC_N-1:0] read_strobes(input ctl_t c);
        return {c.buf_oe, c.rtn_oe, c.ir_oe, c.acc_oe, c.pc_oe, c.mem_rd};
    endfunction

    function automatic alu_op_e alu_sel(input ctl_t c);
        return alu_op_e'({c.fsel_hi, c.fsel_lo});
    endfunction

endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (ld)
            q <= d;
    end
endmodule

// File: rtl/dp_jkff.sv
module dp_jkff (
    input  logic clk,
    input  logic rst,
    input  logic j,
    input  logic k,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= (j & ~q) | (~k & q);
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import acc_dp_pkg::*;
#(
    parameter int W = 16
) (
    input  alu_op_e      op,
    input  logic [W-1:0] arg,
    input  logic [W-1:0] opnd,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            ALU_INC:  res = opnd + W'(1);
            ALU_ADD:  res = arg + opnd;
            ALU_SUB:  res = arg - opnd;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/dp_bus_select.sv
module dp_bus_select #(
    parameter int W = 16,
    parameter int N = 6
) (
    input  logic [N-1:0]        rd_en,
    input  logic [N-1:0][W-1:0] src,
    output logic [W-1:0]        bus,
    output logic                conflict
);
    logic [W-1:0] merged;
    logic         seen;
    logic         multi;

    always_comb begin
        merged = '0;
        seen   = 1'b0;
        multi  = 1'b0;
        for (int i = 0; i < N; i++) begin
            merged = merged | (src[i] & {W{rd_en[i]}});
            multi  = multi | (seen & rd_en[i]);
            seen   = seen | rd_en[i];
        end
    end

    assign conflict = multi;
    assign bus      = multi ? '0 : merged;
endmodule

// File: rtl/bus_accum_datapath.sv
module bus_accum_datapath
    import acc_dp_pkg::*;
#(
    parameter int W    = acc_dp_pkg::WORD_W,
    parameter int OP_W = acc_dp_pkg::OPC_W,
    localparam int AW  = W - OP_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CTL_W-1:0]    ctl,
    input  logic [W-1:0]        mem_rdata,
    output logic [AW-1:0]       mem_addr,
    output logic [W-1:0]        mem_wdata,
    output logic                mem_wr,
    output logic                mem_req,
    output logic                acc_zero,
    output logic [OP_W-1:0]     opcode,
    output logic                iack,
    output logic                bus_conflict
);
    ctl_t c;
    assign c = ctl_t'(ctl);

    logic [W-1:0]  bus;
    logic [W-1:0]  alu_res;
    logic [W-1:0]  pc_q, acc_q, ir_q, rtn_q, arg_q, buf_q;
    logic [AW-1:0] mar_q;
    logic [SRC_N-1:0][W-1:0] srcs;

    always_comb begin
        srcs          = '0;
        srcs[SRC_MEM] = mem_rdata;
        srcs[SRC_PC]  = pc_q;
        srcs[SRC_ACC] = acc_q;
        srcs[SRC_IR]  = ir_q;
        srcs[SRC_RTN] = rtn_q;
        srcs[SRC_BUF] = buf_q;
    end

    dp_bus_select #(.W(W), .N(SRC_N)) u_bus (
        .rd_en    (read_strobes(c)),
        .src      (srcs),
        .bus      (bus),
        .conflict (bus_conflict)
    );

    dp_reg #(.W(AW)) u_mar (.clk(clk), .rst(rst), .ld(c.mar_ld), .d(bus[AW-1:0]), .q(mar_q));
    dp_reg #(.W(W))  u_pc  (.clk(clk), .rst(rst), .ld(c.pc_ld),  .d(bus), .q(pc_q));
    dp_reg #(.W(W))  u_acc (.clk(clk), .rst(rst), .ld(c.acc_ld), .d(bus), .q(acc_q));
    dp_reg #(.W(W))  u_ir  (.clk(clk), .rst(rst), .ld(c.ir_ld),  .d(bus), .q(ir_q));
    dp_reg #(.W(W))  u_rtn (.clk(clk), .rst(rst), .ld(c.rtn_ld), .d(bus), .q(rtn_q));
    dp_reg #(.W(W))  u_arg (.clk(clk), .rst(rst), .ld(c.arg_ld), .d(bus), .q(arg_q));

    dp_alu #(.W(W)) u_alu (
        .op   (alu_sel(c)),
        .arg  (arg_q),
        .opnd (bus),
        .res  (alu_res)
    );

    // result buffer: captured on every edge
    dp_reg #(.W(W)) u_buf (.clk(clk), .rst(rst), .ld(1'b1), .d(alu_res), .q(buf_q));

    dp_jkff u_ack (.clk(clk), .rst(rst), .j(c.rtn_ld), .k(c.rtn_oe), .q(iack));

    assign mem_wr    = c.mem_wr;
    assign mem_req   = c.mem_wr | c.mem_rd;
    assign mem_wdata = c.mem_wr ? bus : '0;
    assign mem_addr  = mar_q;
    assign acc_zero  = (acc_q == '0);
    assign opcode    = ir_q[W-1 -: OP_W];
endmodule

// File: rtl/bus_accum_datapath_chk.sv
module bus_accum_datapath_chk (
    input logic        clk,
    input logic        rst,
    input logic [14:0] ctl,
    input logic [15:0] mem_rdata,
    input logic [12:0] mem_addr,
    input logic [15:0] mem_wdata,
    input logic        mem_wr,
    input logic        mem_req,
    input logic        acc_zero,
    input logic        iack,
    input logic        bus_conflict
);
    logic [5:0] rds;
    assign rds = {ctl[0], ctl[4], ctl[6], ctl[8], ctl[10], ctl[13]};

    p_conflict_flag_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(rds) > 1) |-> bus_conflict);
    p_no_false_conflict_r3: assert property (@(posedge clk) disable iff (rst)
        ($countones(rds) <= 1) |-> !bus_conflict);
    p_conflict_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (bus_conflict && mem_wr) |-> (mem_wdata == 16'h0));
    p_wdata_idle_r7: assert property (@(posedge clk) disable iff (rst)
        !ctl[14] |-> (mem_wdata == 16'h0));
    p_req_r7: assert property (@(posedge clk) disable iff (rst)
        mem_req == (ctl[14] | ctl[13]));
    p_mar_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !ctl[12] |=> $stable(mem_addr));
    p_acc_load_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl[9] && rds == 6'b000001) |=> (acc_zero == ($past(mem_rdata) == 16'h0)));
    p_iack_set_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl[5] && !ctl[4]) |=> iack);
    p_iack_clr_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctl[5] && ctl[4]) |=> !iack);
    p_iack_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctl[5] && !ctl[4]) |=> $stable(iack));
    p_reset_r10: assert property (@(posedge clk)
        rst |=> (!iack && acc_zero && mem_addr == 13'h0));
endmodule

bind bus_accum_datapath bus_accum_datapath_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .mem_rdata    (mem_rdata),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_wr       (mem_wr),
    .mem_req      (mem_req),
    .acc_zero     (acc_zero),
    .iack         (iack),
    .bus_conflict (bus_conflict)
);

// File: tb/tb_bus_accum_datapath.sv
`timescale 1ns/1ps
module tb_bus_accum_datapath;
    // control bit positions (R1)
    localparam logic [14:0] WMEM = 15'h4000, RMEM = 15'h2000, WMAR = 15'h1000,
                            WPC  = 15'h0800, RPC  = 15'h0400, WACC = 15'h0200,
                            RACC = 15'h0100, WIR  = 15'h0080, RIR  = 15'h0040,
                            WRTN = 15'h0020, RRTN = 15'h0010, WARG = 15'h0008,
                            FHI  = 15'h0004, FLO  = 15'h0002, RBUF = 15'h0001;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [14:0] ctl = '0;
    logic [15:0] mem_rdata = '0;
    logic [12:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_wr, mem_req, acc_zero, iack, bus_conflict;
    logic [2:0]  opcode;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_accum_datapath dut (
        .clk(clk), .rst(rst), .ctl(ctl), .mem_rdata(mem_rdata),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wr(mem_wr),
        .mem_req(mem_req), .acc_zero(acc_zero), .opcode(opcode),
        .iack(iack), .bus_conflict(bus_conflict)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one cycle: apply at the falling edge, settle, leave for the next rising edge
    task automatic drive(input logic [14:0] c, input logic [15:0] d);
        @(negedge clk);
        ctl = c;
        mem_rdata = d;
        #1;
    endtask

    task automatic load(input logic [14:0] wr, input logic [15:0] v);
        drive(RMEM | wr, v);
    endtask

    task automatic peek(input logic [14:0] rd, output logic [15:0] v);
        drive(rd | WMEM, 16'h0);
        v = mem_wdata;
    endtask

    function automatic logic [15:0] alu_model(input int op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            3: return b + 16'd1;
            2: return a + b;
            1: return a - b;
            default: return 16'h0;
        endcase
    endfunction

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        #1;
        // R10 reset state
        chk("R10 mem_addr", 32'(mem_addr), 0);
        chk("R10 iack", 32'(iack), 0);
        chk("R10 acc_zero", 32'(acc_zero), 1);
        chk("R10 opcode", 32'(opcode), 0);
        @(negedge clk);
        rst = 1'b0;

        // R7 memory strobes
        drive(RMEM, 16'h1357);
        chk("R7 req on read", 32'(mem_req), 1);
        chk("R7 wr low", 32'(mem_wr), 0);
        chk("R7 wdata zero when not writing", 32'(mem_wdata), 0);
        drive(15'h0, 16'h1357);
        chk("R7 req idle", 32'(mem_req), 0);
        chk("R2 empty bus", 32'(mem_wdata), 0);
        drive(WMEM, 16'h1357);
        chk("R2 no source bus zero", 32'(mem_wdata), 0);
        chk("R7 wr high", 32'(mem_wr), 1);
        drive(WMEM | RMEM, 16'hBEEF);
        chk("R7 wdata passes bus", 32'(mem_wdata), 32'h0000BEEF);
        chk("R7 req on write", 32'(mem_req), 1);

        // R2/R4 load and read back each bus register
        for (int i = 0; i < 8; i++) begin
            logic [15:0] x;
            x = 16'(i * 16'h2491 + 16'h0103);
            load(WPC, x);       peek(RPC, v);  chk("R4 pc load", 32'(v), 32'(x));
            load(WACC, x ^ 16'hFFFF); peek(RACC, v); chk("R4 acc load", 32'(v), 32'(x ^ 16'hFFFF));
            load(WIR, x + 16'd7); peek(RIR, v); chk("R4 ir load", 32'(v), 32'(x + 16'd7));
            load(WRTN, x - 16'd9); peek(RRTN, v); chk("R4 rtn load", 32'(v), 32'(x - 16'd9));
        end

        // R4 register-to-register transfer and hold
        load(WPC, 16'h4321);
        drive(RPC | WACC, 16'h0);
        drive(RMEM | WIR, 16'h7777);
        peek(RACC, v);
        chk("R4 pc to acc transfer", 32'(v), 32'h4321);
        peek(RPC, v);
        chk("R4 pc held", 32'(v), 32'h4321);

        // R9 address field, opcode field, zero flag
        load(WMAR, 16'hF0A5);
        drive(RMEM, 16'h0);
        chk("R9 mem_addr low bits", 32'(mem_addr), 32'h10A5);
        drive(RMEM, 16'h1FFF);
        chk("R4 mar hold", 32'(mem_addr), 32'h10A5);
        for (int op = 0; op < 8; op++) begin
            load(WIR, {3'(op), 13'h0ABC});
            drive(15'h0, 16'h0);
            chk("R9 opcode field", 32'(opcode), 32'(op));
        end
        load(WACC, 16'h0000);
        drive(15'h0, 16'h0);
        chk("R9 acc_zero set", 32'(acc_zero), 1);
        load(WACC, 16'h8000);
        drive(15'h0, 16'h0);
        chk("R9 acc_zero clear", 32'(acc_zero), 0);

        // R5/R6 ALU sweep
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a, b;
            a = (i == 15) ? 16'hFFFF : 16'(16'hFFFF - i * 4099);
            b = (i == 15) ? 16'h0001 : 16'(i * 7919);
            for (int op = 0; op < 4; op++) begin
                load(WARG, a);
                drive(RMEM | (op[1] ? FHI : 15'h0) | (op[0] ? FLO : 15'h0), b);
                peek(RBUF, v);
                chk($sformatf("R5 alu op%0d", op), 32'(v), 32'(alu_model(op, a, b)));
            end
        end
        load(WARG, 16'hFFFF);
        drive(RMEM | FHI | FLO, 16'hFFFF);
        peek(RBUF, v);
        chk("R5 inc wraps", 32'(v), 0);
        load(WARG, 16'h0001);
        drive(RMEM | FHI, 16'h0005);
        drive(15'h0, 16'h0);
        peek(RBUF, v);
        chk("R6 buffer overwritten each clock", 32'(v), 0);

        // R3 exhaustive read strobe sweep
        load(WPC, 16'h1111);
        load(WACC, 16'h2222);
        load(WIR, 16'h3333);
        load(WRTN, 16'h4444);
        for (int m = 0; m < 64; m++) begin
            logic [14:0] c;
            int ones;
            c = (m[0] ? RMEM : 15'h0) | (m[1] ? RPC : 15'h0) | (m[2] ? RACC : 15'h0) |
                (m[3] ? RIR : 15'h0) | (m[4] ? RRTN : 15'h0) | (m[5] ? RBUF : 15'h0);
            ones = int'(m[0]) + int'(m[1]) + int'(m[2]) + int'(m[3]) + int'(m[4]) + int'(m[5]);
            drive(c | WMEM, 16'hA5A5);
            chk($sformatf("R3 conflict flag m=%0d", m), 32'(bus_conflict), (ones > 1) ? 1 : 0);
            if (ones > 1)
                chk($sformatf("R3 bus zero m=%0d", m), 32'(mem_wdata), 0);
            else if (m == 1)
                chk("R2 mem source", 32'(mem_wdata), 32'h0000A5A5);
            else if (m == 2)
                chk("R2 pc source", 32'(mem_wdata), 32'h1111);
            else if (m == 4)
                chk("R2 acc source", 32'(mem_wdata), 32'h2222);
            else if (m == 8)
                chk("R2 ir source", 32'(mem_wdata), 32'h3333);
            else if (m == 16)
                chk("R2 rtn source", 32'(mem_wdata), 32'h4444);
        end
        load(WACC, 16'h0055);
        drive(RMEM | RPC | WACC, 16'h1234);
        drive(15'h0, 16'h0);
        chk("R3 conflicting load gives zero", 32'(acc_zero), 1);

        // R8 interrupt acknowledge flip-flop
        rst = 1'b1;
        drive(15'h0, 16'h0);
        rst = 1'b0;
        drive(15'h0, 16'h0);
        chk("R10 iack cleared", 32'(iack), 0);
        drive(WRTN | RMEM, 16'h0007);
        drive(15'h0, 16'h0);
        chk("R8 set by J", 32'(iack), 1);
        drive(15'h0, 16'h0);
        chk("R8 hold high", 32'(iack), 1);
        drive(WRTN | RMEM, 16'h0008);
        drive(15'h0, 16'h0);
        chk("R8 J with Q high stays", 32'(iack), 1);
        drive(RRTN, 16'h0);
        drive(15'h0, 16'h0);
        chk("R8 cleared by K", 32'(iack), 0);
        drive(RRTN, 16'h0);
        drive(15'h0, 16'h0);
        chk("R8 K with Q low stays", 32'(iack), 0);
        drive(WRTN | RRTN, 16'h0);
        drive(15'h0, 16'h0);
        chk("R8 toggle up", 32'(iack), 1);
        drive(WRTN | RRTN, 16'h0);
        drive(15'h0, 16'h0);
        chk("R8 toggle down", 32'(iack), 0);

        // R10 mid-run reset
        load(WACC, 16'h0009);
        load(WMAR, 16'h0042);
        drive(WRTN | RMEM, 16'h0001);
        rst = 1'b1;
        drive(15'h0, 16'h0);
        drive(15'h0, 16'h0);
        chk("R10 acc cleared", 32'(acc_zero), 1);
        chk("R10 mar cleared", 32'(mem_addr), 0);
        chk("R10 iack reset", 32'(iack), 0);
        rst = 1'b0;
        peek(RPC, v);
        chk("R10 pc cleared", 32'(v), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule